// File: doc/BRIEF.md
# OOK Pulse-Width Packet Decoder with Repeat Confirmation

This block turns the sliced data line of an on-off keyed receiver into confirmed packets. Each bit begins with a rising edge and always returns low before the next bit. The length of the high pulse carries the value: a short mark of about one time unit means 0 and a long mark of about two units means 1. The block measures the marks against a time base of `CLK_PER_MS` clock cycles per millisecond. The stream has no preamble and no sync word. A packet therefore starts at the first rising edge after a quiet line and ends when the line stays low for longer than any bit could.

Transmitters of this kind repeat a packet several times, with a low pause of up to 32 ms between copies. The block keeps the first copy it receives as a reference. It raises the valid strobe only when the next copy has the full bit count and is identical to that reference. Pulses of the wrong width and over-long lows inside a packet abort the packet and pulse the error output. A long quiet period drops the reference.

A small state machine runs the framing. Its states are:
- `ST_IDLE`: no packet and no reference timing.
- `ST_MARK`: measuring a high pulse.
- `ST_SPACE`: measuring a low inside a packet.
- `ST_GAP`: the packet has ended and the block waits for the next copy or for the reference timeout.
- `ST_RECOVER`: after an abort, the block waits for a clean low.

Its transitions are:
- IDLE→MARK and GAP→MARK on a rising edge.
- MARK→SPACE on a falling edge after a mark of valid width.
- MARK→RECOVER on a bad width, or when the mark outlasts the longest legal width.
- SPACE→MARK on a rising edge after a legal low.
- SPACE→RECOVER on a rising edge after an over-long low.
- SPACE→GAP when the low reaches the end-of-packet time.
- GAP→IDLE when the low reaches the reference timeout.
- RECOVER→GAP once the line has been low for the end-of-packet time.

Top module: `ook_pwm_decoder`

## Requirements
- R1: The line passes a two-flop synchroniser and a three-sample majority vote, so a high lasting a single clock cycle is ignored: it neither starts a packet nor raises `pkt_error`.
- R2: A high pulse lasting at least 0.5 ms and less than 1.5 ms decodes as bit 0.
- R3: A high pulse lasting from 1.5 ms to 2.5 ms decodes as bit 1.
- R4: A high pulse shorter than 0.5 ms or longer than 2.5 ms aborts the packet. It pulses `pkt_error` for one cycle and discards the stored reference copy.
- R5: Inside a packet, a low lasting more than 4 ms that is ended by a rising edge before 5 ms aborts the packet and pulses `pkt_error`.
- R6: A low reaching 5 ms ends the packet without error, and the next rising edge starts a new packet.
- R7: The first complete copy after the reference is cleared is stored as the reference and produces no strobe.
- R8: A copy of exactly `NBITS` bits that equals the reference pulses `pkt_valid` for one cycle. `pkt_data` then holds the bits, with the first received bit in bit `NBITS-1` and the last in bit 0.
- R9: A full-length copy that differs from the reference produces no strobe and becomes the new reference.
- R10: After a strobe, further identical copies produce no strobe until the reference is cleared.
- R11: A low lasting more than 40 ms after a packet clears the reference, so the copy that follows is only stored.
- R12: A copy whose bit count is not `NBITS` produces no strobe and no error, and it clears the reference.
- R13: After reset, `pkt_valid`, `pkt_error` and `pkt_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Sliced on-off keyed data line, asynchronous |
| pkt_data | output | NBITS | Last confirmed packet, first bit in the MSB |
| pkt_valid | output | 1 | One-cycle strobe when a repeat confirms a packet |
| pkt_error | output | 1 | One-cycle pulse when a packet is aborted |

## Verification
A wrong framing state shows up within one packet. A missed end of packet merges two copies into one over-long copy, so the strobe that should follow the second copy never comes. A wrong width decision shows up either as a mismatch in `pkt_data` or as a spurious `pkt_error` pulse one cycle after the offending edge. A reference that is kept or dropped at the wrong moment shows on the next copy: a strobe is missing, doubled, or confirms data from before a long idle. The bench therefore counts strobes and errors across whole copy sequences rather than probing intermediate timing.

// File: rtl/ook_pkg.sv
package ook_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_GAP,
        ST_RECOVER
    } frame_state_t;
endpackage

// File: rtl/ook_line_filter.sv
module ook_line_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [1:0] sync_q;
    logic [2:0] win_q;
    logic       lvl_q;
    logic       lvl_d;
    logic       vote;

    assign vote = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            win_q  <= '0;
            lvl_q  <= 1'b0;
            lvl_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], din};
            win_q  <= {win_q[1:0], sync_q[1]};
            lvl_q  <= vote;
            lvl_d  <= lvl_q;
        end
    end

    assign level = lvl_q;
    assign rise  = lvl_q & ~lvl_d;
    assign fall  = ~lvl_q & lvl_d;

    // R1: the vote cannot pass a filtered high shorter than two cycles
    a_r1_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> level);
endmodule

// File: rtl/ook_frame_fsm.sv
module ook_frame_fsm
    import ook_pkg::*;
#(
    parameter int CLK_PER_MS = 50000,
    parameter int NBITS      = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             level,
    input  logic                             rise,
    input  logic                             fall,
    output logic                             frm_done,
    output logic [NBITS-1:0]                 frm_data,
    output logic [$clog2(NBITS+2)-1:0]       frm_len,
    output logic                             abort,
    output logic                             ref_clr
);
    localparam int CNT_W = $clog2(40 * CLK_PER_MS + 1);
    localparam int LEN_W = $clog2(NBITS + 2);
    localparam logic [CNT_W-1:0] C_MIN0 = CNT_W'(CLK_PER_MS / 2);
    localparam logic [CNT_W-1:0] C_MIN1 = CNT_W'((3 * CLK_PER_MS) / 2);
    localparam logic [CNT_W-1:0] C_MAX1 = CNT_W'((5 * CLK_PER_MS) / 2);
    localparam logic [CNT_W-1:0] C_LOWERR = CNT_W'(4 * CLK_PER_MS);
    localparam logic [CNT_W-1:0] C_END  = CNT_W'(5 * CLK_PER_MS);
    localparam logic [CNT_W-1:0] C_IDLE = CNT_W'(40 * CLK_PER_MS);
    localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(NBITS + 1);

    frame_state_t state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [NBITS-1:0] shreg;
    logic [LEN_W-1:0] nbits;
    logic is_zero, is_one;
    logic ev_abort, ev_done, ev_clr, ev_bit;

    assign is_zero = (cnt >= C_MIN0) && (cnt < C_MIN1);
    assign is_one  = (cnt >= C_MIN1) && (cnt <= C_MAX1);

    always_comb begin
        nxt      = state;
        ev_abort = 1'b0;
        ev_done  = 1'b0;
        ev_clr   = 1'b0;
        ev_bit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rise) nxt = ST_MARK;
            end
            ST_MARK: begin
                if (fall) begin
                    if (is_zero || is_one) begin
                        nxt    = ST_SPACE;
                        ev_bit = 1'b1;
                    end else begin
                        nxt      = ST_RECOVER;
                        ev_abort = 1'b1;
                    end
                end else if (cnt > C_MAX1) begin
                    nxt      = ST_RECOVER;
                    ev_abort = 1'b1;
                end
            end
            ST_SPACE: begin
                if (rise) begin
                    if (cnt > C_LOWERR) begin
                        nxt      = ST_RECOVER;
                        ev_abort = 1'b1;
                    end else begin
                        nxt = ST_MARK;
                    end
                end else if (cnt >= C_END) begin
                    nxt     = ST_GAP;
                    ev_done = 1'b1;
                end
            end
            ST_GAP: begin
                if (rise) begin
                    nxt = ST_MARK;
                end else if (cnt >= C_IDLE) begin
                    nxt    = ST_IDLE;
                    ev_clr = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (!level && cnt >= C_END) nxt = ST_GAP;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // timing, shift register and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            nbits    <= '0;
            frm_done <= 1'b0;
            abort    <= 1'b0;
            ref_clr  <= 1'b0;
        end else begin
            if (rise || fall)    cnt <= '0;
            else if (cnt != C_IDLE) cnt <= cnt + 1'b1;
            if ((state == ST_IDLE || state == ST_GAP) && rise) begin
                shreg <= '0;
                nbits <= '0;
            end else if (ev_bit) begin
                shreg <= {shreg[NBITS-2:0], is_one};
                if (nbits != LEN_SAT) nbits <= nbits + 1'b1;
            end
            frm_done <= ev_done;
            abort    <= ev_abort;
            ref_clr  <= ev_clr | ev_abort;
        end
    end

    assign frm_data = shreg;
    assign frm_len  = nbits;

    // R6: a packet only ends after the line has been low
    a_r6_done_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> $past(!level));
    // R2: every finished packet carries at least one decoded bit
    a_r2_nonempty_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> (frm_len != '0));
endmodule

// File: rtl/ook_repeat_check.sv
module ook_repeat_check #(
    parameter int NBITS = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frm_done,
    input  logic [NBITS-1:0]             frm_data,
    input  logic [$clog2(NBITS+2)-1:0]   frm_len,
    input  logic                         ref_clr,
    output logic                         pkt_valid,
    output logic [NBITS-1:0]             pkt_data
);
    localparam int LEN_W = $clog2(NBITS + 2);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(NBITS);

    logic             ref_valid;
    logic             matched;
    logic [NBITS-1:0] ref_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            matched   <= 1'b0;
            ref_data  <= '0;
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if (ref_clr) begin
                ref_valid <= 1'b0;
                matched   <= 1'b0;
            end else if (frm_done) begin
                if (frm_len != LEN_FULL) begin
                    ref_valid <= 1'b0;
                    matched   <= 1'b0;
                end else if (ref_valid && frm_data == ref_data) begin
                    if (!matched) begin
                        pkt_valid <= 1'b1;
                        pkt_data  <= frm_data;
                        matched   <= 1'b1;
                    end
                end else begin
                    ref_data  <= frm_data;
                    ref_valid <= 1'b1;
                    matched   <= 1'b0;
                end
            end
        end
    end

    // R8: a strobe always stems from a held reference
    a_r8_valid_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (ref_valid && matched));
    // R10: the strobe lasts exactly one cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);
    // R11: a clear request drops the reference
    a_r11_clear_drops_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ref_clr |=> !ref_valid);
endmodule

// File: rtl/ook_pwm_decoder.sv
module ook_pwm_decoder #(
    parameter int CLK_PER_MS = 50000,
    parameter int NBITS      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    output logic [NBITS-1:0] pkt_data,
    output logic             pkt_valid,
    output logic             pkt_error
);
    localparam int LEN_W = $clog2(NBITS + 2);

    logic             level, rise, fall;
    logic             frm_done, abort, ref_clr;
    logic [NBITS-1:0] frm_data;
    logic [LEN_W-1:0] frm_len;

    ook_line_filter u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .level (level),
        .rise  (rise),
        .fall  (fall)
    );

    ook_frame_fsm #(
        .CLK_PER_MS (CLK_PER_MS),
        .NBITS      (NBITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .rise     (rise),
        .fall     (fall),
        .frm_done (frm_done),
        .frm_data (frm_data),
        .frm_len  (frm_len),
        .abort    (abort),
        .ref_clr  (ref_clr)
    );

    ook_repeat_check #(
        .NBITS (NBITS)
    ) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_len   (frm_len),
        .ref_clr   (ref_clr),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data)
    );

    assign pkt_error = abort;

    // R4: an error pulse is never given together with a strobe
    a_r4_err_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_error && pkt_valid));
endmodule

// File: tb/test_ook_pwm_decoder.sv
module test_ook_pwm_decoder;
    localparam int CPM   = 20;
    localparam int NB    = 12;
    localparam int T_ONE = CPM;
    localparam int T_TWO = 2 * CPM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b0;
    logic [NB-1:0] pkt_data;
    logic          pkt_valid;
    logic          pkt_error;

    int n_checks = 0;
    int n_fail   = 0;
    int n_valid  = 0;
    int n_err    = 0;
    logic [NB-1:0] last_data = '0;
    bit done = 1'b0;

    localparam logic [15:0] PAT_A = 16'h0B2D; // 1011_0010_1101, ends with 1
    localparam logic [15:0] PAT_B = 16'h0B2C; // differs in the last bit

    always #10 clk = ~clk; // 50 MHz

    ook_pwm_decoder #(.CLK_PER_MS(CPM), .NBITS(NB)) i_ook_pwm_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .pkt_data  (pkt_data),
        .pkt_valid (pkt_valid),
        .pkt_error (pkt_error)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) begin
                n_valid   <= n_valid + 1;
                last_data <= pkt_data;
            end
            if (pkt_error) n_err <= n_err + 1;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic hold(input logic lv, input int cycles);
        rx_line = lv;
        repeat (cycles) @(negedge clk);
    endtask

    // bits sent first-to-last from bit n-1 down to 0; the last low is extended by gap
    task automatic send_pkt(input logic [15:0] d, input int n, input int gap);
        for (int i = n - 1; i >= 0; i--) begin
            hold(1'b1, d[i] ? T_TWO : T_ONE);
            hold(1'b0, (d[i] ? T_ONE : T_TWO) + ((i == 0) ? gap : 0));
        end
    endtask

    task automatic idle_clear();
        hold(1'b0, 1000);
    endtask

    task automatic t_reset();
        check("R13 valid at reset", int'(pkt_valid), 0);
        check("R13 error at reset", int'(pkt_error), 0);
        check("R13 data at reset", int'(pkt_data), 0);
    endtask

    task automatic t_match();
        int v0, e0;
        idle_clear();
        v0 = n_valid; e0 = n_err;
        send_pkt(PAT_A, NB, 600);
        check("R7 first copy no strobe", n_valid - v0, 0);
        send_pkt(PAT_A, NB, 300);
        check("R8 repeat strobes once", n_valid - v0, 1);
        check("R2 R3 R8 data bits MSB first", int'(last_data), int'(PAT_A[NB-1:0]));
        check("R2 R3 no error on clean copies", n_err - e0, 0);
        send_pkt(PAT_A, NB, 300);
        send_pkt(PAT_A, NB, 300);
        check("R10 later repeats silent", n_valid - v0, 1);
    endtask

    task automatic t_mismatch();
        int v0;
        idle_clear();
        v0 = n_valid;
        send_pkt(PAT_A, NB, 300);
        send_pkt(PAT_B, NB, 300);
        check("R9 differing copy no strobe", n_valid - v0, 0);
        send_pkt(PAT_B, NB, 300);
        check("R9 new reference confirmed", n_valid - v0, 1);
        check("R9 confirmed data", int'(last_data), int'(PAT_B[NB-1:0]));
    endtask

    task automatic t_long_idle();
        int v0;
        idle_clear();
        v0 = n_valid;
        send_pkt(PAT_A, NB, 900);
        send_pkt(PAT_A, NB, 300);
        check("R11 reference dropped by long idle", n_valid - v0, 0);
        send_pkt(PAT_A, NB, 300);
        check("R11 next pair confirms", n_valid - v0, 1);
    endtask

    task automatic t_length();
        int v0, e0;
        idle_clear();
        v0 = n_valid; e0 = n_err;
        send_pkt(PAT_A, NB - 1, 300);
        send_pkt(PAT_A, NB - 1, 300);
        check("R12 short copies no strobe", n_valid - v0, 0);
        send_pkt(PAT_A, NB, 300);
        send_pkt(PAT_A, NB + 1, 300);
        send_pkt(PAT_A, NB, 300);
        check("R12 long copy clears reference", n_valid - v0, 0);
        check("R12 length mismatch not an error", n_err - e0, 0);
        send_pkt(PAT_A, NB, 300);
        check("R12 recovery strobe", n_valid - v0, 1);
    endtask

    task automatic t_glitch();
        int v0, e0;
        idle_clear();
        v0 = n_valid; e0 = n_err;
        hold(1'b1, 1);
        hold(1'b0, 200);
        check("R1 idle glitch no error", n_err - e0, 0);
        send_pkt(PAT_A, NB, 150);
        hold(1'b1, 1);
        hold(1'b0, 150);
        send_pkt(PAT_A, NB, 300);
        check("R1 gap glitch ignored", n_valid - v0, 1);
        check("R1 no error from glitches", n_err - e0, 0);
    endtask

    task automatic t_bad_width();
        int v0, e0;
        idle_clear();
        e0 = n_err;
        hold(1'b1, 4);
        hold(1'b0, 200);
        check("R4 short pulse error", n_err - e0, 1);
        hold(1'b1, 70);
        hold(1'b0, 200);
        check("R4 long pulse error", n_err - e0, 2);
        v0 = n_valid;
        send_pkt(PAT_A, NB, 300);
        hold(1'b1, 4);
        hold(1'b0, 300);
        send_pkt(PAT_A, NB, 300);
        check("R4 abort clears reference", n_valid - v0, 0);
        send_pkt(PAT_A, NB, 300);
        check("R4 recovery strobe", n_valid - v0, 1);
    endtask

    task automatic t_low_limits();
        int v0, e0;
        idle_clear();
        e0 = n_err;
        hold(1'b1, T_TWO);
        hold(1'b0, 90);
        hold(1'b1, T_TWO);
        hold(1'b0, 300);
        check("R5 over-long low inside packet", n_err - e0, 1);
        idle_clear();
        v0 = n_valid; e0 = n_err;
        send_pkt(PAT_A, NB, 90);
        send_pkt(PAT_A, NB, 300);
        check("R6 5.5 ms low splits copies", n_valid - v0, 1);
        check("R6 split without error", n_err - e0, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_match();
        t_mismatch();
        t_long_idle();
        t_length();
        t_glitch();
        t_bad_width();
        t_low_limits();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule